// File: doc/BRIEF.md
# Display Window Shadow Register Bank

This block keeps the control fields of five display windows in two copies. Software writes a staging copy through a simple register write port. A live copy drives the display logic, and the staging copy moves into it only on a vertical sync strobe, so a frame never starts with fields from two different updates. The fields held are window origin, window extent, frame-buffer base address, blend alpha, colour key and a window enable. Window 0 has no blend alpha and no colour key.

Each window has a protect bit. While it is set, vsync leaves that window's live fields alone, however many strobes arrive. Software sets protect, writes any number of fields, then clears protect. All the values it staged then reach the live copy together at the next vsync. A pending flag per window shows that staged values are waiting for transfer.

Writes select a window and a field code. The data word carries the field value. Protect is the only setting that acts at once. Everything else, including turning a window off, waits for vsync.

Top module: `wsr_bank`

## Requirements
- R1: After reset every live field reads zero, every window is disabled, and no protect or pending flag is set.
- R2: A write with `wr_en` high, window index `wr_win` and field code `wr_field` updates only the staging copy. The codes are: 0 origin (x in data[11:0], y in data[27:16]), 1 extent (width in data[11:0], height in data[27:16]), 2 base address (data[31:0]), 3 alpha (data[11:0]), 4 colour key (data[23:0]), 5 control (bit 0 enable, bit 1 protect). Live outputs do not change without a vsync, and the window's pending flag is set from the cycle after the write.
- R3: On a cycle with `vsync` high, every unprotected window copies all of its staged fields to its live outputs in the following cycle, and its pending flag clears.
- R4: On a vsync, a window whose protect bit is set keeps all of its live fields and its pending flag, for any number of vsync strobes.
- R5: After a window's protect bit is cleared, every value staged while it was protected appears on the live outputs together at the next vsync.
- R6: Clearing a window's enable through the control field leaves `win_en` high until the next vsync. The live enable falls only after a vsync.
- R7: Window 0 ignores alpha and colour-key writes. Its live alpha and key stay zero, and such a write does not set its pending flag. Windows 1 to 4 accept both fields.
- R8: A write to one window changes no staged value, live value or pending flag of any other window.
- R9: When a write and a vsync fall in the same cycle for an unprotected window, the live copy takes the value staged before that write. The pending flag stays set, and the new value goes live at the following vsync.
- R10: A control write changes `win_protect` in the next cycle, without waiting for vsync. Writes with a window index of 5 or above, or with a field code of 6 or 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging copy |
| wr_win | input | 3 | Target window index |
| wr_field | input | 3 | Field code of the write |
| wr_data | input | 32 | Write data |
| vsync | input | 1 | One-cycle vertical sync strobe |
| win_en | output | 5 | Live enable, one bit per window |
| win_protect | output | 5 | Protect bit, one per window |
| win_pending | output | 5 | Staged values waiting for transfer, one per window |
| win_x | output | 5x12 | Live origin x per window |
| win_y | output | 5x12 | Live origin y per window |
| win_w | output | 5x12 | Live width per window |
| win_h | output | 5x12 | Live height per window |
| win_base | output | 5x32 | Live frame-buffer base per window |
| win_alpha | output | 5x12 | Live blend alpha per window (window 0 reads zero) |
| win_key | output | 5x24 | Live colour key per window (window 0 reads zero) |

## Verification
The hardest situation to reach is a protected window that is passed over by two vsync strobes while it holds several staged fields, and then has all of them applied in one step after protect clears. The stimulus sets protect, stages extent and base, sends two vsync strobes, and checks both fields and the pending flag after each strobe. It then clears protect with the same control write that turns the window on, and checks that the fields and the enable all appear after the next strobe. A write placed in the very cycle of a vsync is the other hard case. The bench drives both strobes on the same edge, so the stale-versus-new ordering is checked directly.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  // Field codes presented on wr_field
  typedef enum logic [2:0] {
    FLD_ORIGIN = 3'd0,
    FLD_EXTENT = 3'd1,
    FLD_BASE   = 3'd2,
    FLD_ALPHA  = 3'd3,
    FLD_KEY    = 3'd4,
    FLD_CTRL   = 3'd5
  } wsr_field_e;

  // Second coordinate of a pair starts here in the data word
  localparam int WSR_Y_LSB      = 16;
  localparam int WSR_CTRL_EN    = 0;
  localparam int WSR_CTRL_PROT  = 1;
endpackage

// File: rtl/wsr_decode.sv
module wsr_decode #(
  parameter int NUM_WIN   = 5,
  parameter int WIN_IDX_W = 3
) (
  input  logic                 wr_en,
  input  logic [WIN_IDX_W-1:0] wr_win,
  output logic [NUM_WIN-1:0]   win_we
);
  // One strobe per window; indices past the last window hit nothing
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_sel
    assign win_we[i] = wr_en && (wr_win == WIN_IDX_W'(i));
  end
endmodule

// File: rtl/wsr_window.sv
module wsr_window
  import wsr_pkg::*;
#(
  parameter int POS_W     = 12,
  parameter int ADDR_W    = 32,
  parameter int ALPHA_W   = 12,
  parameter int KEY_W     = 24,
  parameter int DATA_W    = 32,
  parameter bit HAS_BLEND = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         field,
  input  logic [DATA_W-1:0]  data,
  input  logic               vsync,
  output logic [POS_W-1:0]   act_x,
  output logic [POS_W-1:0]   act_y,
  output logic [POS_W-1:0]   act_w,
  output logic [POS_W-1:0]   act_h,
  output logic [ADDR_W-1:0]  act_base,
  output logic [ALPHA_W-1:0] act_alpha,
  output logic [KEY_W-1:0]   act_key,
  output logic               act_en,
  output logic               prot,
  output logic               pend
);
  localparam int YH = WSR_Y_LSB + POS_W - 1;

  logic [POS_W-1:0]  stg_x_q, stg_y_q, stg_w_q, stg_h_q;
  logic [POS_W-1:0]  stg_x_d, stg_y_d, stg_w_d, stg_h_d;
  logic [ADDR_W-1:0] stg_base_q, stg_base_d;
  logic              stg_en_q, stg_en_d;
  logic              prot_q, prot_d, pend_q, pend_d;
  logic [POS_W-1:0]  act_x_q, act_y_q, act_w_q, act_h_q;
  logic [ADDR_W-1:0] act_base_q;
  logic              act_en_q;
  logic              xfer, blend_fld, accept;

  assign xfer      = vsync && !prot_q;
  assign blend_fld = (field == FLD_ALPHA) || (field == FLD_KEY);
  assign accept    = we && (field <= FLD_CTRL) && (HAS_BLEND || !blend_fld);

  always_comb begin
    stg_x_d    = stg_x_q;
    stg_y_d    = stg_y_q;
    stg_w_d    = stg_w_q;
    stg_h_d    = stg_h_q;
    stg_base_d = stg_base_q;
    stg_en_d   = stg_en_q;
    prot_d     = prot_q;
    case (field)
      FLD_ORIGIN: begin
        stg_x_d = data[POS_W-1:0];
        stg_y_d = data[YH:WSR_Y_LSB];
      end
      FLD_EXTENT: begin
        stg_w_d = data[POS_W-1:0];
        stg_h_d = data[YH:WSR_Y_LSB];
      end
      FLD_BASE: stg_base_d = data[ADDR_W-1:0];
      FLD_CTRL: begin
        stg_en_d = data[WSR_CTRL_EN];
        prot_d   = data[WSR_CTRL_PROT];
      end
      default: ;
    endcase
    pend_d = accept | (pend_q & ~xfer);
  end

  // Staging copy: enabled by an accepted write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_x_q    <= '0;
      stg_y_q    <= '0;
      stg_w_q    <= '0;
      stg_h_q    <= '0;
      stg_base_q <= '0;
      stg_en_q   <= 1'b0;
      prot_q     <= 1'b0;
    end else if (accept) begin
      stg_x_q    <= stg_x_d;
      stg_y_q    <= stg_y_d;
      stg_w_q    <= stg_w_d;
      stg_h_q    <= stg_h_d;
      stg_base_q <= stg_base_d;
      stg_en_q   <= stg_en_d;
      prot_q     <= prot_d;
    end
  end

  // Live copy: enabled by an unprotected vsync
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_x_q    <= '0;
      act_y_q    <= '0;
      act_w_q    <= '0;
      act_h_q    <= '0;
      act_base_q <= '0;
      act_en_q   <= 1'b0;
    end else if (xfer) begin
      act_x_q    <= stg_x_q;
      act_y_q    <= stg_y_q;
      act_w_q    <= stg_w_q;
      act_h_q    <= stg_h_q;
      act_base_q <= stg_base_q;
      act_en_q   <= stg_en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  if (HAS_BLEND) begin : g_blend
    logic [ALPHA_W-1:0] stg_a_q, act_a_q;
    logic [KEY_W-1:0]   stg_k_q, act_k_q;
    logic               a_we, k_we;
    assign a_we = we && (field == FLD_ALPHA);
    assign k_we = we && (field == FLD_KEY);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stg_a_q <= '0;
      else if (a_we) stg_a_q <= data[ALPHA_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stg_k_q <= '0;
      else if (k_we) stg_k_q <= data[KEY_W-1:0];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_a_q <= '0;
        act_k_q <= '0;
      end else if (xfer) begin
        act_a_q <= stg_a_q;
        act_k_q <= stg_k_q;
      end
    end
    assign act_alpha = act_a_q;
    assign act_key   = act_k_q;
  end else begin : g_noblend
    assign act_alpha = '0;
    assign act_key   = '0;
  end

  assign act_x    = act_x_q;
  assign act_y    = act_y_q;
  assign act_w    = act_w_q;
  assign act_h    = act_h_q;
  assign act_base = act_base_q;
  assign act_en   = act_en_q;
  assign prot     = prot_q;
  assign pend     = pend_q;
endmodule

// File: rtl/wsr_bank.sv
module wsr_bank #(
  parameter int NUM_WIN   = 5,
  parameter int POS_W     = 12,
  parameter int ADDR_W    = 32,
  parameter int ALPHA_W   = 12,
  parameter int KEY_W     = 24,
  parameter int DATA_W    = 32,
  localparam int WIN_IDX_W = $clog2(NUM_WIN)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [WIN_IDX_W-1:0]            wr_win,
  input  logic [2:0]                      wr_field,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            vsync,
  output logic [NUM_WIN-1:0]              win_en,
  output logic [NUM_WIN-1:0]              win_protect,
  output logic [NUM_WIN-1:0]              win_pending,
  output logic [NUM_WIN-1:0][POS_W-1:0]   win_x,
  output logic [NUM_WIN-1:0][POS_W-1:0]   win_y,
  output logic [NUM_WIN-1:0][POS_W-1:0]   win_w,
  output logic [NUM_WIN-1:0][POS_W-1:0]   win_h,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_base,
  output logic [NUM_WIN-1:0][ALPHA_W-1:0] win_alpha,
  output logic [NUM_WIN-1:0][KEY_W-1:0]   win_key
);
  logic [NUM_WIN-1:0] win_we;

  wsr_decode #(.NUM_WIN(NUM_WIN), .WIN_IDX_W(WIN_IDX_W)) u_dec (
    .wr_en  (wr_en),
    .wr_win (wr_win),
    .win_we (win_we)
  );

  // Window 0 is built without blend alpha and colour key
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    wsr_window #(
      .POS_W(POS_W), .ADDR_W(ADDR_W), .ALPHA_W(ALPHA_W),
      .KEY_W(KEY_W), .DATA_W(DATA_W), .HAS_BLEND(i != 0)
    ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (win_we[i]),
      .field     (wr_field),
      .data      (wr_data),
      .vsync     (vsync),
      .act_x     (win_x[i]),
      .act_y     (win_y[i]),
      .act_w     (win_w[i]),
      .act_h     (win_h[i]),
      .act_base  (win_base[i]),
      .act_alpha (win_alpha[i]),
      .act_key   (win_key[i]),
      .act_en    (win_en[i]),
      .prot      (win_protect[i]),
      .pend      (win_pending[i])
    );
  end
endmodule

// File: rtl/wsr_bank_chk.sv
module wsr_bank_chk #(
  parameter int NUM_WIN   = 5,
  parameter int ADDR_W    = 32,
  parameter int WIN_IDX_W = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [WIN_IDX_W-1:0]           wr_win,
  input logic                           vsync,
  input logic [NUM_WIN-1:0]             win_en,
  input logic [NUM_WIN-1:0]             win_protect,
  input logic [NUM_WIN-1:0]             win_pending,
  input logic [NUM_WIN-1:0][ADDR_W-1:0] win_base
);
  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> ($stable(win_base) && $stable(win_en)));

  // R10
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (32'(wr_win) >= NUM_WIN) && !vsync) |=> $stable(win_pending));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_w
    // R3
    xfer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !win_protect[w] && !(wr_en && (wr_win == WIN_IDX_W'(w))))
      |=> !win_pending[w]);
    // R4
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && win_protect[w]) |=> $stable(win_base[w]));
    // R4
    prot_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && win_protect[w] && win_pending[w]) |=> win_pending[w]);
    // R6
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(win_en[w]) |-> $past(vsync));
  end
endmodule

bind wsr_bank wsr_bank_chk #(
  .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WIN_IDX_W(WIN_IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .vsync(vsync),
  .win_en(win_en), .win_protect(win_protect), .win_pending(win_pending),
  .win_base(win_base)
);

// File: tb/sim_wsr_bank.sv
`timescale 1ns/1ps
module sim_wsr_bank;
  logic clk, rst_n, wr_en, vsync;
  logic [2:0]  wr_win, wr_field;
  logic [31:0] wr_data;
  logic [4:0]  win_en, win_protect, win_pending;
  logic [4:0][11:0] win_x, win_y, win_w, win_h, win_alpha;
  logic [4:0][31:0] win_base;
  logic [4:0][23:0] win_key;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  wsr_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
    .wr_field(wr_field), .wr_data(wr_data), .vsync(vsync),
    .win_en(win_en), .win_protect(win_protect), .win_pending(win_pending),
    .win_x(win_x), .win_y(win_y), .win_w(win_w), .win_h(win_h),
    .win_base(win_base), .win_alpha(win_alpha), .win_key(win_key)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] w, logic [2:0] f, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_win = w; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic vs();
    @(negedge clk);
    vsync = 1;
    @(negedge clk);
    vsync = 0;
  endtask

  task automatic t_reset();
    chk("R1 en", 64'(win_en), 0);
    chk("R1 protect", 64'(win_protect), 0);
    chk("R1 pending", 64'(win_pending), 0);
    chk("R1 base", 64'(win_base[4]), 0);
    chk("R1 x", 64'(win_x[0]), 0);
  endtask

  task automatic t_stage_apply();
    wr(1, 0, {4'h0, 12'd7, 4'h0, 12'd5});
    chk("R2 x held", 64'(win_x[1]), 0);
    chk("R2 pending", 64'(win_pending), 5'b00010);
    vs();
    chk("R3 x", 64'(win_x[1]), 5);
    chk("R3 y", 64'(win_y[1]), 7);
    chk("R3 pending clear", 64'(win_pending), 0);
  endtask

  task automatic t_isolation();
    wr(2, 2, 32'hDEAD_0000);
    chk("R8 other pending", 64'(win_pending), 5'b00100);
    vs();
    chk("R8 base w2", 64'(win_base[2]), 32'hDEAD_0000);
    chk("R8 base w3", 64'(win_base[3]), 0);
    chk("R8 x w1 kept", 64'(win_x[1]), 5);
  endtask

  task automatic t_protect();
    wr(3, 5, 32'h2);
    chk("R10 protect now", 64'(win_protect), 5'b01000);
    wr(3, 1, {4'h0, 12'd50, 4'h0, 12'd100});
    wr(3, 2, 32'h0000_1234);
    vs();
    chk("R4 w held", 64'(win_w[3]), 0);
    chk("R4 base held", 64'(win_base[3]), 0);
    chk("R4 pending kept", 64'(win_pending[3]), 1);
    vs();
    chk("R4 second vsync", 64'(win_base[3]), 0);
    wr(3, 5, 32'h1);
    chk("R10 unprotect", 64'(win_protect), 0);
    chk("R5 en before vsync", 64'(win_en[3]), 0);
    vs();
    chk("R5 w", 64'(win_w[3]), 100);
    chk("R5 h", 64'(win_h[3]), 50);
    chk("R5 base", 64'(win_base[3]), 32'h1234);
    chk("R5 en", 64'(win_en[3]), 1);
    chk("R5 pending", 64'(win_pending), 0);
  endtask

  task automatic t_disable();
    wr(3, 5, 32'h0);
    chk("R6 still on", 64'(win_en[3]), 1);
    vs();
    chk("R6 off", 64'(win_en[3]), 0);
  endtask

  task automatic t_blend();
    wr(0, 3, 32'hABC);
    wr(0, 4, 32'h123456);
    chk("R7 w0 no pending", 64'(win_pending), 0);
    wr(1, 3, 32'hABC);
    wr(1, 4, 32'h654321);
    vs();
    chk("R7 w0 alpha", 64'(win_alpha[0]), 0);
    chk("R7 w0 key", 64'(win_key[0]), 0);
    chk("R7 w1 alpha", 64'(win_alpha[1]), 12'hABC);
    chk("R7 w1 key", 64'(win_key[1]), 24'h654321);
  endtask

  task automatic t_collide();
    wr(4, 2, 32'h11);
    vs();
    @(negedge clk);
    wr_en = 1; wr_win = 4; wr_field = 2; wr_data = 32'h22; vsync = 1;
    @(negedge clk);
    wr_en = 0; vsync = 0;
    chk("R9 old value", 64'(win_base[4]), 32'h11);
    chk("R9 pending kept", 64'(win_pending[4]), 1);
    vs();
    chk("R9 new value", 64'(win_base[4]), 32'h22);
    chk("R9 pending clear", 64'(win_pending[4]), 0);
  endtask

  task automatic t_bad();
    wr(5, 2, 32'hFFFF);
    wr(7, 2, 32'hFFFF);
    wr(1, 7, 32'hFFFF);
    chk("R10 no pending", 64'(win_pending), 0);
    vs();
    chk("R10 base w4", 64'(win_base[4]), 32'h22);
    chk("R10 base w1", 64'(win_base[1]), 0);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; vsync = 0; wr_win = 0; wr_field = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stage_apply();
    t_isolation();
    t_protect();
    t_disable();
    t_blend();
    t_collide();
    t_bad();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule